// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bit-level slave side of a two-wire serial bus for a small memory. It runs on a fast system clock and oversamples the bus clock and data lines. Both lines pass through synchronisers and an edge detector. The block recognises start and stop conditions and shifts bytes in on rising bus-clock edges. It drives read data out after falling bus-clock edges. It never drives the data line high: it only produces an enable that pulls the line low.

The first byte after a start selects the device. It must carry the fixed type code 1010 in its upper four bits. The next three bits must equal the strap inputs, and the lowest bit is the direction. In a write, the byte after the device byte is reported to the storage side as a word address, and every later byte as data. In a read, the block asks the storage side for a byte with a load strobe. It keeps sending bytes for as long as the master acknowledges each one. While the storage side reports an internal write cycle in progress, the block refuses to acknowledge even its own address. A master can therefore poll for completion. A stop after a selected transfer is reported with a one-cycle pulse.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `wr_valid_o`, `rd_load_o` and `stop_o` are all 0.
- R2: `stop_o` pulses for one cycle when a stop condition (data rising while the bus clock is high) ends a transfer in which the device byte was acknowledged. A stop after an unselected transfer gives no pulse, and a repeated start gives no pulse.
- R3: A device byte is acknowledged only when bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 = 1 means read and 0 means write. The acknowledge pulls the data line low for the whole ninth clock. On a mismatch, the block releases the line and ignores the bus until the next start: there is no acknowledge and no event.
- R4: While `busy_i` is 1 at the end of the eighth device-byte bit, a matching device byte is not acknowledged.
- R5: In a write, each received byte is acknowledged. Each one gives a single `wr_valid_o` pulse with the byte on `wr_byte_o`. `wr_is_addr_o` is 1 for the first byte after the device byte and 0 for later bytes.
- R6: In a read, `rd_load_o` pulses once for each byte sent, as `rd_data_i` is taken. That byte goes out MSB first, and each bit changes after a falling bus-clock edge. The line is released for the ninth clock.
- R7: A master acknowledge (low in the ninth clock) makes the block load and send the next byte. A master non-acknowledge ends the read: no further load, and the line stays released.
- R8: A start in the middle of any transfer, including mid-byte, restarts device-byte reception with a cleared bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| strap_i | input | 3 | Strapped device select bits |
| busy_i | input | 1 | Storage side is in an internal write cycle |
| rd_data_i | input | 8 | Byte at the storage side's current address |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wr_valid_o | output | 1 | One-cycle pulse: a written byte was received |
| wr_is_addr_o | output | 1 | Qualifies `wr_valid_o`: the byte is the word address |
| wr_byte_o | output | 8 | Received byte, valid with `wr_valid_o` |
| rd_load_o | output | 1 | One-cycle pulse: `rd_data_i` was taken for sending |
| stop_o | output | 1 | One-cycle pulse: a selected transfer ended with stop |

## Verification
The address decision and a change of the busy flag can fall on the same system-clock edge. Both act at the falling bus-clock edge that ends the eighth device-byte bit. The bench drives `busy_i` in the same half-cycle in which it drops the bus clock after that bit, in both directions. The acknowledge slot must then follow the new busy value: busy raised there gives no acknowledge, and busy cleared there gives one. A scoreboard queue judges the write events that follow, and a model of the storage address counter judges the read bytes.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int TYPE_W   = BYTE_W - STRAP_W - 1;
  localparam logic [TYPE_W-1:0] DEV_TYPE = 4'b1010;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,   // receiving device byte
    ST_RX,    // receiving write byte
    ST_ACK,   // slave drives acknowledge
    ST_TX,    // slave sends read byte
    ST_MACK   // master acknowledge slot
  } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/twi_cond.sv
module twi_cond (
  input  logic scl_i,
  input  logic scl_prev_i,
  input  logic sda_i,
  input  logic sda_prev_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_held;
  assign scl_held = scl_i & scl_prev_i;
  assign start_o  = scl_held & sda_prev_i & ~sda_i;
  assign stop_o   = scl_held & ~sda_prev_i & sda_i;
  assign rise_o   = scl_i & ~scl_prev_i;
  assign fall_o   = ~scl_i & scl_prev_i;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_mem_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               wr_valid_o,
  output logic               wr_is_addr_o,
  output logic [BYTE_W-1:0]  wr_byte_o,
  output logic               rd_load_o,
  output logic               stop_o
);
  twi_state_e        state_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rw_q, first_q, sel_q, mack_q;
  logic              hit;

  assign hit = (sh_q[BYTE_W-1 -: TYPE_W] == DEV_TYPE) && (sh_q[STRAP_W:1] == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sh_q         <= '0;
      cnt_q        <= '0;
      rw_q         <= 1'b0;
      first_q      <= 1'b0;
      sel_q        <= 1'b0;
      mack_q       <= 1'b0;
      sda_oe_o     <= 1'b0;
      wr_valid_o   <= 1'b0;
      wr_is_addr_o <= 1'b0;
      wr_byte_o    <= '0;
      rd_load_o    <= 1'b0;
      stop_o       <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_load_o  <= 1'b0;
      stop_o     <= 1'b0;
      if (start_i) begin
        state_q  <= ST_DEV;
        cnt_q    <= '0;
        sel_q    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        stop_o   <= sel_q;
        sel_q    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_RX: begin
            if (rise_i && cnt_q != CNT_W'(BYTE_W)) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              if (state_q == ST_DEV) begin
                if (hit && !busy_i) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh_q[0];
                  first_q  <= 1'b1;
                  sel_q    <= 1'b1;
                  state_q  <= ST_ACK;
                end else begin
                  state_q  <= ST_IDLE;
                end
              end else begin
                sda_oe_o     <= 1'b1;
                wr_valid_o   <= 1'b1;
                wr_is_addr_o <= first_q;
                wr_byte_o    <= sh_q;
                first_q      <= 1'b0;
                state_q      <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q      <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[BYTE_W-1];
                rd_load_o <= 1'b1;
                state_q   <= ST_TX;
              end else begin
                sda_oe_o  <= 1'b0;
                state_q   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (fall_i) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[BYTE_W-2];
                cnt_q    <= cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise_i) mack_q <= ~sda_i;
            else if (fall_i) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q      <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[BYTE_W-1];
                rd_load_o <= 1'b1;
                state_q   <= ST_TX;
              end else begin
                state_q   <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               wr_valid_o,
  output logic               wr_is_addr_o,
  output logic [BYTE_W-1:0]  wr_byte_o,
  output logic               rd_load_o,
  output logic               stop_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, syn, prv;
  logic start_det, stop_det, rise_det, fall_det;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    twi_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw[g]),
      .q_o    (syn[g]),
      .prev_o (prv[g])
    );
  end

  twi_cond i_cond (
    .scl_i      (syn[1]),
    .scl_prev_i (prv[1]),
    .sda_i      (syn[0]),
    .sda_prev_i (prv[0]),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .rise_o     (rise_det),
    .fall_o     (fall_det)
  );

  twi_slave_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_det),
    .stop_i       (stop_det),
    .rise_i       (rise_det),
    .fall_i       (fall_det),
    .sda_i        (syn[0]),
    .strap_i      (strap_i),
    .busy_i       (busy_i),
    .rd_data_i    (rd_data_i),
    .sda_oe_o     (sda_oe_o),
    .wr_valid_o   (wr_valid_o),
    .wr_is_addr_o (wr_is_addr_o),
    .wr_byte_o    (wr_byte_o),
    .rd_load_o    (rd_load_o),
    .stop_o       (stop_o)
  );
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rd_data_i,
  input logic       sda_oe_o,
  input logic       wr_valid_o,
  input logic       rd_load_o,
  input logic       stop_o
);
  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!sda_oe_o && !wr_valid_o && !rd_load_o && !stop_o);
  end

  assert_stop_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !sda_oe_o);

  assert_stop_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);

  assert_wr_acked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> sda_oe_o);

  assert_events_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_o, rd_load_o, stop_o}));

  assert_load_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_o |=> !rd_load_o);

  assert_load_msb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_o |-> (sda_oe_o == !$past(rd_data_i[7])));
endmodule

bind twi_mem_slave twi_mem_slave_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_data_i  (rd_data_i),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o),
  .rd_load_o  (rd_load_o),
  .stop_o     (stop_o)
);

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_oe, wr_valid, wr_is_addr, rd_load, stop_p;
  logic [7:0] wr_byte, rd_data;
  logic sda_bus;
  int checks = 0, errors = 0, stop_cnt = 0, rd_cnt = 0;
  logic [8:0] exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  function automatic logic [7:0] mem_at(int k);
    return 8'((k * 8'h3B) + 8'h5C);
  endfunction
  assign rd_data = mem_at(rd_cnt);

  twi_mem_slave i_twi_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(STRAP),
    .busy_i(busy), .rd_data_i(rd_data), .sda_oe_o(sda_oe), .wr_valid_o(wr_valid),
    .wr_is_addr_o(wr_is_addr), .wr_byte_o(wr_byte), .rd_load_o(rd_load), .stop_o(stop_p)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // storage-side model and scoreboard monitor
  always @(negedge clk) begin
    if (rd_load) rd_cnt++;
    if (stop_p) stop_cnt++;
    if (wr_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write event", {wr_is_addr, wr_byte}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({wr_is_addr, wr_byte} == e, "R5 write event", {wr_is_addr, wr_byte}, e);
      end
    end
  end

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; qwait(); m_scl = 1'b1; qwait(); seen = sda_bus; qwait(); m_scl = 1'b0; qwait();
  endtask

  // busy_sw >= 0 changes busy together with the falling edge after bit 0
  task automatic wr_byte_t(input logic [7:0] b, output logic ack, input int busy_sw = -1);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qwait(); m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0;
      if (i == 0 && busy_sw >= 0) busy = busy_sw[0];
      qwait();
    end
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte_t(output logic [7:0] b, input logic give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] b;
    int base, st0;
    repeat (5) @(negedge clk);
    chk(!sda_oe && !wr_valid && !rd_load && !stop_p, "R1 reset outputs", sda_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!sda_oe && stop_cnt == 0 && rd_cnt == 0, "R1 quiet after reset", sda_oe, 0);

    // byte then page write
    bus_start();
    wr_byte_t(DEV_W, ack);           chk(ack, "R3 address ack", ack, 1);
    exp_q.push_back({1'b1, 8'h47});
    wr_byte_t(8'h47, ack);           chk(ack, "R5 word address ack", ack, 1);
    exp_q.push_back({1'b0, 8'h12});
    wr_byte_t(8'h12, ack);           chk(ack, "R5 data ack", ack, 1);
    exp_q.push_back({1'b0, 8'hE9});
    wr_byte_t(8'hE9, ack);           chk(ack, "R5 data ack 2", ack, 1);
    st0 = stop_cnt;
    bus_stop(); qwait();
    chk(stop_cnt == st0 + 1, "R2 stop pulse", stop_cnt - st0, 1);
    chk(exp_q.size() == 0, "R5 all events seen", exp_q.size(), 0);

    // strap mismatch, then a following byte is ignored
    bus_start();
    wr_byte_t({4'b1010, 3'b001, 1'b0}, ack); chk(!ack, "R3 strap mismatch nack", ack, 0);
    wr_byte_t(8'h00, ack);                   chk(!ack, "R3 ignored after mismatch", ack, 0);
    st0 = stop_cnt;
    bus_stop(); qwait();
    chk(stop_cnt == st0, "R2 no stop pulse unselected", stop_cnt - st0, 0);

    // wrong type code
    bus_start();
    wr_byte_t({4'b1011, STRAP, 1'b0}, ack); chk(!ack, "R3 type mismatch nack", ack, 0);
    bus_stop();

    // polling while busy
    busy = 1'b1;
    bus_start();
    wr_byte_t(DEV_W, ack);  chk(!ack, "R4 busy nack", ack, 0);
    st0 = stop_cnt;
    bus_stop(); qwait();
    chk(stop_cnt == st0, "R4 no stop pulse while polled", stop_cnt - st0, 0);
    // busy clears in the decision cycle
    bus_start();
    wr_byte_t(DEV_W, ack, 0); chk(ack, "R4 busy cleared at decision", ack, 1);
    bus_stop();
    // busy rises in the decision cycle
    bus_start();
    wr_byte_t(DEV_W, ack, 1); chk(!ack, "R4 busy raised at decision", ack, 0);
    bus_stop();
    busy = 1'b0;

    // sequential read with master acks then nack
    base = rd_cnt;
    bus_start();
    wr_byte_t(DEV_R, ack); chk(ack, "R3 read address ack", ack, 1);
    for (int j = 0; j < 3; j++) begin
      rd_byte_t(b, j != 2);
      chk(b == mem_at(base + j), "R6 read byte", b, mem_at(base + j));
    end
    chk(rd_cnt == base + 3, "R7 loads stop after nack", rd_cnt - base, 3);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    chk(!sda_oe, "R7 line released after nack", sda_oe, 0);
    m_scl = 1'b0; qwait();
    chk(rd_cnt == base + 3 && !sda_oe, "R7 extra clock ignored", rd_cnt - base, 3);
    st0 = stop_cnt;
    bus_stop(); qwait();
    chk(stop_cnt == st0 + 1, "R2 stop after read", stop_cnt - st0, 1);

    // random read: dummy write, repeated start, read
    st0 = stop_cnt;
    bus_start();
    wr_byte_t(DEV_W, ack); chk(ack, "R8 dummy write ack", ack, 1);
    exp_q.push_back({1'b1, 8'h10});
    wr_byte_t(8'h10, ack);
    bus_start();
    chk(stop_cnt == st0, "R8 no stop on repeated start", stop_cnt - st0, 0);
    base = rd_cnt;
    wr_byte_t(DEV_R, ack); chk(ack, "R8 read after restart ack", ack, 1);
    rd_byte_t(b, 1'b0);
    chk(b == mem_at(base), "R6 random read byte", b, mem_at(base));
    bus_stop(); qwait();
    chk(stop_cnt == st0 + 1, "R2 single stop for random read", stop_cnt - st0, 1);

    // start in the middle of a byte
    bus_start();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b0, s);
    bus_start();
    wr_byte_t(DEV_W, ack); chk(ack, "R8 mid-byte restart ack", ack, 1);
    exp_q.push_back({1'b1, 8'h22});
    wr_byte_t(8'h22, ack); chk(ack, "R8 word address after restart", ack, 1);
    bus_stop(); qwait();
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule